// File: doc/BRIEF.md
# Manchester Word Decoder

This block turns the sampled serial Manchester stream of one bus receiver into parallel 16-bit words. It runs at ten samples per bit time. It finds the three-bit-time sync waveform and sorts it into command/status or data. It then tracks the bit phase, re-centring itself on each mid-bit transition, and shifts in sixteen data bits and a parity bit. Each finished word comes out on a one-clock strobe with its type and two error flags: missing mid-bit transition and bad parity.

A command sync raises a one-clock early-warning pulse while the word body has not yet started. The protocol logic can use it to prepare a response. An active-low enable from the receiver gates the whole decoder. While the enable is inactive, nothing is reported and the decoder stays in its idle state.

Top module: `mdec_rx`

## Requirements
- R1: After reset, word_valid, word_data, word_is_cmd, man_err, par_err and cmd_sync_pulse are all 0.
- R2: A command word (rx_in high for 15 samples, then low for 15, then 17 Manchester bits sent most significant first, a 1 sent as high-then-low and a 0 as low-then-high, 5 samples per half) produces exactly one word_valid pulse of one clock. The pulse carries word_data equal to the 16 data bits and word_is_cmd = 1.
- R3: The data sync (low 15, then high 15) gives word_is_cmd = 0. It is recognised only when its first half begins at the end of the previous word, as in a back-to-back transfer. A data sync that rises out of a long low idle line yields no word.
- R4: Each accepted command sync gives exactly one cmd_sync_pulse of one clock, and it arrives before that word's word_valid. A data sync gives none.
- R5: Each sync half may be 13 to 17 samples long. With the data bits following the actual second half, the word still decodes correctly.
- R6: A sync first half of 12 or fewer samples, or 18 or more, yields no word and no cmd_sync_pulse.
- R7: A transition after 12 or fewer samples of the sync second half cancels the word: no word and no cmd_sync_pulse.
- R8: Parity is odd over the 16 data bits plus the parity bit. An even count sets par_err = 1 and the word is still delivered with its data.
- R9: A bit with no transition in its middle window sets man_err = 1, and the word is still delivered.
- R10: While rx_en_n is 1, no word_valid and no cmd_sync_pulse occur. After rx_en_n returns to 0, a later word decodes normally.
- R11: The error flags belong to each word. A clean word after a faulty one reports man_err = 0 and par_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, ten per bit time |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en_n | input | 1 | Receiver enable, active low |
| rx_in | input | 1 | Serial Manchester data from the receiver |
| word_valid | output | 1 | One-clock strobe for a finished word |
| word_data | output | 16 | Decoded data bits, first received bit in bit 15 |
| word_is_cmd | output | 1 | 1 when the sync marked a command/status word |
| man_err | output | 1 | Some bit of the word lacked a mid-bit transition |
| par_err | output | 1 | Odd parity check failed for the word |
| cmd_sync_pulse | output | 1 | One-clock pulse on an accepted command sync |

## Verification
The hardest case to reach is a data sync. A low first half cannot be timed from an edge, so the decoder only sees it when the word boundary follows directly on the previous word. The bench therefore sends a command word and a data word with no gap, both at exact nominal timing, so that the decoder's own boundary lines up with the data sync. The other hard cases are the tolerance limits. The bench uses data whose first bit starts with a transition, so each shortened or stretched sync half has a clean, measurable length. It also sends one such stretched sync half-waveform after a long low idle, which must be rejected.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [1:0] {
    SD_IDLE   = 2'd0,
    SD_SECOND = 2'd1,
    SD_BUSY   = 2'd2
  } sd_state_t;

  // true when a measured run length lies inside nominal +/- tolerance
  function automatic logic len_ok(input int len, input int nom, input int tol);
    return (len >= nom - tol) && (len <= nom + tol);
  endfunction

  // odd parity: the XOR of all bits, parity bit included, must be 1
  function automatic logic odd_par_ok(input logic [16:0] bits);
    return ^bits;
  endfunction

endpackage

// File: rtl/mdec_line_cond.sv
module mdec_line_cond #(
  parameter int RUN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             bound_clr,
  output logic             lvl,
  output logic             lvl_prev,
  output logic             lvl_edge,
  output logic [RUN_W-1:0] run_len
);

  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta     <= 1'b0;
      lvl      <= 1'b0;
      lvl_prev <= 1'b0;
    end else begin
      meta     <= rx_in;
      lvl      <= meta;
      lvl_prev <= lvl;
    end
  end

  assign lvl_edge = lvl ^ lvl_prev;

  // samples of the previous level seen before the current cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_len <= RUN_MAX;
    else if (bound_clr)      run_len <= '0;
    else if (lvl_edge)       run_len <= {{(RUN_W-1){1'b0}}, 1'b1};
    else if (run_len != RUN_MAX) run_len <= run_len + 1'b1;
  end

  // R3
  run_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_edge && !bound_clr) |=> (run_len == {{(RUN_W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/mdec_sync_det.sv
module mdec_sync_det
  import mdec_pkg::*;
#(
  parameter int SPB   = 10,
  parameter int TOL   = 2,
  parameter int RUN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             lvl_edge,
  input  logic             lvl_prev,
  input  logic [RUN_W-1:0] run_len,
  input  logic             word_done,
  output logic             start_data,
  output logic             is_cmd,
  output logic             cmd_sync
);

  localparam int HALF      = SPB / 2;
  localparam int SYNC_HALF = 3 * HALF;
  localparam int CNT_W     = $clog2(SYNC_HALF + 1);
  localparam logic [CNT_W-1:0] MIN_OK  = CNT_W'(SYNC_HALF - TOL);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SYNC_HALF);
  localparam logic [CNT_W-1:0] CNT_BEG = CNT_W'(2);

  sd_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             first_ok;

  assign first_ok = lvl_edge && len_ok(int'(run_len), SYNC_HALF, TOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SD_IDLE;
      cnt        <= '0;
      is_cmd     <= 1'b0;
      cmd_sync   <= 1'b0;
      start_data <= 1'b0;
    end else if (!enable) begin
      state      <= SD_IDLE;
      cmd_sync   <= 1'b0;
      start_data <= 1'b0;
    end else begin
      cmd_sync   <= 1'b0;
      start_data <= 1'b0;
      case (state)
        SD_IDLE: begin
          if (first_ok) begin
            state  <= SD_SECOND;
            cnt    <= CNT_BEG;
            is_cmd <= lvl_prev;
          end
        end
        SD_SECOND: begin
          if (lvl_edge && (cnt <= MIN_OK)) begin
            state <= SD_IDLE;
          end else begin
            if (cnt == MIN_OK) cmd_sync <= is_cmd;
            if (cnt == CNT_END) begin
              state      <= SD_BUSY;
              start_data <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        SD_BUSY: begin
          if (word_done) state <= SD_IDLE;
        end
        default: state <= SD_IDLE;
      endcase
    end
  end

  // R4
  sync_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sync |=> !cmd_sync);

  // R4
  sync_pulse_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sync |-> (is_cmd && state == SD_SECOND));

endmodule

// File: rtl/mdec_bit_slicer.sv
module mdec_bit_slicer #(
  parameter int SPB   = 10,
  parameter int TOL   = 2,
  parameter int DBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             lvl,
  input  logic             lvl_prev,
  input  logic             lvl_edge,
  output logic             busy,
  output logic             word_done,
  output logic [DBITS:0]   word_bits,
  output logic             word_man
);

  localparam int HALF  = SPB / 2;
  localparam int WBITS = DBITS + 1;
  localparam int PH_W  = $clog2(SPB);
  localparam int IDX_W = $clog2(WBITS + 1);
  localparam logic [PH_W-1:0]  WIN_LO   = PH_W'(HALF - TOL);
  localparam logic [PH_W-1:0]  WIN_HI   = PH_W'(HALF + TOL);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SPB - 1);
  localparam logic [PH_W-1:0]  PH_AFTER = PH_W'(HALF + 1);
  localparam logic [PH_W-1:0]  PH_ONE   = PH_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WBITS - 1);

  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;
  logic             got_mid;
  logic             first_v;
  logic             man_acc;
  logic [DBITS:0]   shreg;
  logic             in_win;
  logic             mid_hit;
  logic             bit_end;
  logic             cur_bit;
  logic             bit_bad;

  assign in_win    = (ph >= WIN_LO) && (ph <= WIN_HI);
  assign mid_hit   = busy && lvl_edge && in_win && !got_mid;
  assign bit_end   = busy && !mid_hit && (ph == PH_LAST);
  assign cur_bit   = got_mid ? first_v : lvl;
  assign bit_bad   = !got_mid;
  assign word_done = bit_end && (idx == IDX_LAST);
  assign word_bits = {shreg[DBITS-1:0], cur_bit};
  assign word_man  = man_acc | bit_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ph      <= '0;
      idx     <= '0;
      got_mid <= 1'b0;
      first_v <= 1'b0;
      man_acc <= 1'b0;
      shreg   <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      ph      <= PH_ONE;
      idx     <= '0;
      got_mid <= 1'b0;
      man_acc <= 1'b0;
    end else if (busy) begin
      if (mid_hit) begin
        got_mid <= 1'b1;
        first_v <= lvl_prev;
        ph      <= PH_AFTER;
      end else if (bit_end) begin
        shreg   <= word_bits;
        man_acc <= word_man;
        got_mid <= 1'b0;
        ph      <= '0;
        idx     <= idx + 1'b1;
        if (idx == IDX_LAST) busy <= 1'b0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  // R2
  slicer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R2
  slicer_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= IDX_LAST));

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
  import mdec_pkg::*;
#(
  parameter int SPB   = 10,
  parameter int TOL   = 2,
  parameter int DBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en_n,
  input  logic             rx_in,
  output logic             word_valid,
  output logic [DBITS-1:0] word_data,
  output logic             word_is_cmd,
  output logic             man_err,
  output logic             par_err,
  output logic             cmd_sync_pulse
);

  localparam int SYNC_HALF = 3 * (SPB / 2);
  localparam int RUN_W     = $clog2(SYNC_HALF + TOL + 2);

  logic             enable;
  logic             lvl;
  logic             lvl_prev;
  logic             lvl_edge;
  logic [RUN_W-1:0] run_len;
  logic             start_data;
  logic             sd_is_cmd;
  logic             sd_cmd_sync;
  logic             sl_busy;
  logic             word_done;
  logic [DBITS:0]   word_bits;
  logic             word_man;

  assign enable = !rx_en_n;

  mdec_line_cond #(.RUN_W(RUN_W)) i_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_in    (rx_in),
    .bound_clr(word_done),
    .lvl      (lvl),
    .lvl_prev (lvl_prev),
    .lvl_edge (lvl_edge),
    .run_len  (run_len)
  );

  mdec_sync_det #(.SPB(SPB), .TOL(TOL), .RUN_W(RUN_W)) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .lvl_edge  (lvl_edge),
    .lvl_prev  (lvl_prev),
    .run_len   (run_len),
    .word_done (word_done),
    .start_data(start_data),
    .is_cmd    (sd_is_cmd),
    .cmd_sync  (sd_cmd_sync)
  );

  mdec_bit_slicer #(.SPB(SPB), .TOL(TOL), .DBITS(DBITS)) i_slicer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .start    (start_data),
    .lvl      (lvl),
    .lvl_prev (lvl_prev),
    .lvl_edge (lvl_edge),
    .busy     (sl_busy),
    .word_done(word_done),
    .word_bits(word_bits),
    .word_man (word_man)
  );

  assign cmd_sync_pulse = sd_cmd_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid  <= 1'b0;
      word_data   <= '0;
      word_is_cmd <= 1'b0;
      man_err     <= 1'b0;
      par_err     <= 1'b0;
    end else if (word_done && enable) begin
      word_valid  <= 1'b1;
      word_data   <= word_bits[DBITS:1];
      word_is_cmd <= sd_is_cmd;
      man_err     <= word_man;
      par_err     <= !odd_par_ok(word_bits);
    end else begin
      word_valid  <= 1'b0;
    end
  end

  // R2
  word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_n |=> (!word_valid && !cmd_sync_pulse));

  // R4
  sync_before_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sync_pulse |-> !sl_busy);

  // R2
  word_after_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(sl_busy));

endmodule

// File: tb/test_mdec_rx.sv
`timescale 1ns/1ps
module test_mdec_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en_n = 1'b0;
  logic        rx_in = 1'b0;
  logic        word_valid;
  logic [15:0] word_data;
  logic        word_is_cmd;
  logic        man_err;
  logic        par_err;
  logic        cmd_sync_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nv = 0;
  int ns = 0;
  int vcyc = 0;
  int scyc = 0;
  bit finished = 1'b0;
  logic [15:0] cap_data [0:3];
  logic        cap_cmd  [0:3];
  logic        cap_man  [0:3];
  logic        cap_par  [0:3];

  always #2.5 clk = ~clk;

  mdec_rx i_mdec_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en_n       (rx_en_n),
    .rx_in         (rx_in),
    .word_valid    (word_valid),
    .word_data     (word_data),
    .word_is_cmd   (word_is_cmd),
    .man_err       (man_err),
    .par_err       (par_err),
    .cmd_sync_pulse(cmd_sync_pulse)
  );

  always @(negedge clk) begin
    cyc++;
    if (word_valid) begin
      if (nv < 4) begin
        cap_data[nv] = word_data;
        cap_cmd[nv]  = word_is_cmd;
        cap_man[nv]  = man_err;
        cap_par[nv]  = par_err;
      end
      nv++;
      vcyc = cyc;
    end
    if (cmd_sync_pulse) begin
      ns++;
      scyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_in = v;
    end
  endtask

  task automatic send_body(input logic [15:0] d, input bit flip, input int bad);
    logic p;
    for (int i = 15; i >= 0; i--) begin
      if (i == bad) drive(d[i], 10);
      else begin
        drive(d[i], 5);
        drive(~d[i], 5);
      end
    end
    p = ~(^d);
    if (flip) p = ~p;
    drive(p, 5);
    drive(~p, 5);
  endtask

  task automatic send_word(input bit cmd, input logic [15:0] d, input int l1,
                           input int l2, input bit flip, input int bad);
    drive(cmd, l1);
    drive(~cmd, l2);
    send_body(d, flip, bad);
  endtask

  task automatic clear_mon();
    @(negedge clk);
    nv = 0;
    ns = 0;
  endtask

  task automatic t_reset();
    chk(word_valid == 0 && word_data == 0 && word_is_cmd == 0 && man_err == 0 &&
        par_err == 0 && cmd_sync_pulse == 0, "R1 reset outputs",
        {word_valid, word_is_cmd, man_err, par_err, cmd_sync_pulse, word_data}, 0);
  endtask

  task automatic t_cmd_basic();
    clear_mon();
    send_word(1, 16'hA5C3, 15, 15, 0, -1);
    drive(0, 20);
    chk(nv == 1, "R2 one word", nv, 1);
    chk(cap_data[0] == 16'hA5C3, "R2 data", cap_data[0], 16'hA5C3);
    chk(cap_cmd[0] == 1, "R2 command type", cap_cmd[0], 1);
    chk(cap_man[0] == 0 && cap_par[0] == 0, "R2 no errors",
        {cap_man[0], cap_par[0]}, 0);
    chk(ns == 1, "R4 one sync pulse", ns, 1);
    chk(scyc < vcyc, "R4 pulse before word", scyc, vcyc);
  endtask

  task automatic t_chain();
    clear_mon();
    send_word(1, 16'h1234, 15, 15, 0, -1);
    send_word(0, 16'hBEEF, 15, 15, 0, -1);
    drive(0, 20);
    chk(nv == 2, "R3 two words", nv, 2);
    chk(cap_data[1] == 16'hBEEF, "R3 data word value", cap_data[1], 16'hBEEF);
    chk(cap_cmd[1] == 0, "R3 data type", cap_cmd[1], 0);
    chk(ns == 1, "R4 no pulse for data sync", ns, 1);
  endtask

  task automatic t_data_idle();
    clear_mon();
    drive(0, 40);
    send_word(0, 16'hFFFF, 15, 15, 0, -1);
    drive(0, 30);
    chk(nv == 0 && ns == 0, "R3 data sync from idle ignored", nv + ns, 0);
  endtask

  task automatic t_parity();
    clear_mon();
    send_word(1, 16'h00F0, 15, 15, 1, -1);
    drive(0, 20);
    chk(nv == 1 && cap_data[0] == 16'h00F0, "R8 word delivered", cap_data[0], 16'h00F0);
    chk(cap_par[0] == 1, "R8 parity flag", cap_par[0], 1);
    chk(cap_man[0] == 0, "R8 no manchester flag", cap_man[0], 0);
  endtask

  task automatic t_manchester();
    clear_mon();
    send_word(1, 16'h5A5A, 15, 15, 0, 9);
    drive(0, 20);
    chk(nv == 1 && cap_data[0] == 16'h5A5A, "R9 word delivered", cap_data[0], 16'h5A5A);
    chk(cap_man[0] == 1, "R9 manchester flag", cap_man[0], 1);
    chk(cap_par[0] == 0, "R9 parity clean", cap_par[0], 0);
  endtask

  task automatic t_flags_clear();
    clear_mon();
    send_word(1, 16'h0F0F, 15, 15, 0, -1);
    drive(0, 20);
    chk(nv == 1 && cap_man[0] == 0 && cap_par[0] == 0, "R11 flags cleared",
        {cap_man[0], cap_par[0]}, 0);
  endtask

  task automatic t_tolerance(input int l1, input int l2);
    clear_mon();
    send_word(1, 16'hC3A5, l1, l2, 0, -1);
    drive(0, 25);
    chk(nv == 1 && cap_data[0] == 16'hC3A5 && cap_man[0] == 0,
        $sformatf("R5 sync %0d/%0d accepted", l1, l2), cap_data[0], 16'hC3A5);
    chk(ns == 1, "R5 sync pulse", ns, 1);
  endtask

  task automatic t_reject(input int l1, input int l2, input string req);
    clear_mon();
    send_word(1, 16'hC3A5, l1, l2, 0, -1);
    drive(0, 30);
    chk(nv == 0 && ns == 0, $sformatf("%s sync %0d/%0d rejected", req, l1, l2),
        nv + ns, 0);
  endtask

  task automatic t_disable();
    clear_mon();
    rx_en_n = 1'b1;
    send_word(1, 16'h8001, 15, 15, 0, -1);
    drive(0, 20);
    chk(nv == 0 && ns == 0, "R10 disabled quiet", nv + ns, 0);
    rx_en_n = 1'b0;
    drive(0, 10);
    send_word(1, 16'h8001, 15, 15, 0, -1);
    drive(0, 20);
    chk(nv == 1 && cap_data[0] == 16'h8001, "R10 resumes", cap_data[0], 16'h8001);
  endtask

  task automatic t_values();
    clear_mon();
    send_word(1, 16'h0000, 15, 15, 0, -1);
    drive(0, 20);
    send_word(1, 16'hFFFF, 15, 15, 0, -1);
    drive(0, 20);
    chk(nv == 2 && cap_data[0] == 16'h0000, "R2 all zeros", cap_data[0], 0);
    chk(cap_data[1] == 16'hFFFF && cap_par[1] == 0, "R2 all ones", cap_data[1], 16'hFFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    drive(0, 10);
    t_reset();
    t_cmd_basic();
    t_chain();
    t_data_idle();
    t_parity();
    t_flags_clear();
    t_manchester();
    t_flags_clear();
    t_tolerance(13, 15);
    t_tolerance(17, 15);
    t_tolerance(15, 13);
    t_tolerance(15, 17);
    t_reject(12, 15, "R6");
    t_reject(18, 15, "R6");
    t_reject(15, 12, "R7");
    t_reject(15, 11, "R7");
    t_disable();
    t_values();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule